// File: doc/BRIEF.md
# Configurable SPI Master Engine

This block is a serial peripheral master for a single device with one chip select. A host hands it a fixed-width transmit word through a request and ready handshake. The block drops chip select, exchanges the word most significant bit first over MOSI and MISO, raises chip select again, and returns the received word with a one-cycle valid pulse.

The serial clock is not generated by a free-running divider. A controller steps through half-periods. Each half-period is timed by its own countdown register, one for the idle-level phase and one for the active-level phase. Both countdowns load the divider setting, so every half-period lasts `div + 1` system clocks. The internal clock always idles low. An output mux inverts it when clock polarity is set. Clock phase only selects which edge loads the receive shifter and which edge advances the transmit shifter. The divider and mode are captured when a request is accepted and stay fixed until chip select rises.

Top module: `spi_host_engine`

## Requirements
- R1: After reset, `cs_no` is 1, `rx_valid_o` is 0, `ready_o` is 1 and `sclk_o` is 0.
- R2: While idle, `sclk_o` sits at the polarity bit `mode_i[1]` that was present on the previous clock.
- R3: During a transfer, consecutive `sclk_o` edges are exactly `div_i + 1` system clocks apart, which gives a period of `2*(div_i+1)`. A value of 0 gives half the system clock and 255 gives 1/512. Exactly `2*WORD_W` edges occur per transfer, and the internal clock toggles only while `cs_no` is low.
- R4: The first `sclk_o` edge comes `div_i + 1` clocks after `cs_no` falls. `cs_no` rises `div_i + 1` clocks after the last edge.
- R5: MOSI carries `tx_word_i` MSB first. With `mode_i[0]`=0, bits change on even-numbered edges and the MSB is valid from the fall of chip select. With `mode_i[0]`=1, bits change on odd-numbered edges after the first. Edges are counted from 1 within the transfer.
- R6: MISO is captured on odd-numbered edges when `mode_i[0]`=0 and on even-numbered edges when it is 1, MSB first, and it forms `rx_word_o`.
- R7: `rx_valid_o` is high for exactly one clock: the first clock with `cs_no` high after a transfer. `rx_word_o` holds the received word during that clock.
- R8: Changes to `div_i`, `mode_i` or `tx_word_i` after acceptance have no effect on the running transfer.
- R9: A request is accepted only when `ready_o` is high, and `ready_o` stays low while `cs_no` is low. A request held high through completion starts the next transfer with `cs_no` high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer request |
| ready_o | output | 1 | Idle, so a request can be accepted |
| tx_word_i | input | WORD_W | Word to send |
| div_i | input | DIV_W | Extra hold cycles per half-period |
| mode_i | input | 2 | Bit 1 is clock polarity, bit 0 is clock phase |
| rx_word_o | output | WORD_W | Received word |
| rx_valid_o | output | 1 | One-clock pulse that qualifies `rx_word_o` |
| sclk_o | output | 1 | Serial clock pin |
| cs_no | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The completion pulse of one transfer and the acceptance of the next request can land in the same clock. In that clock the engine is idle, publishing `rx_word_o` and sampling `req_i` all at once. The bench provokes this by holding `req_i` high across the end of a transfer while a different transmit word and slave word wait. It judges the result by three checks: the first word returns intact, chip select is high for exactly one clock, and the second transfer keeps correct edge spacing and payloads in both directions.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TRAIL = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
    } clk_mode_t;

endpackage

// File: rtl/spi_hold_timer.sv
module spi_hold_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
        expired_o = run_i && (cnt_q == '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/spi_clk_polarity.sv
module spi_clk_polarity (
    input  logic sclk_i,
    input  logic invert_i,
    output logic sclk_o
);

    always_comb begin
        sclk_o = invert_i ? ~sclk_i : sclk_i;
    end

endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
    import spi_host_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    output logic              ready_o,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [1:0]        mode_i,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o,
    output logic              sclk_o,
    output logic              cs_no,
    output logic              mosi_o,
    input  logic              miso_i
);

    localparam int HALF_N = 2 * WORD_W;
    localparam int HALF_W = $clog2(HALF_N);
    localparam int NUM_PH = 2;
    localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(HALF_N - 1);

    typedef struct packed {
        eng_state_e        st;
        logic [HALF_W-1:0] half;
        logic [DIV_W-1:0]  div;
        clk_mode_t         mode;
        logic              cs_n;
        logic              sclk;
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
        logic [WORD_W-1:0] rx_out;
        logic              rx_vld;
    } eng_regs_t;

    eng_regs_t r_d, r_q;

    // Phase 0 times the idle-level half, phase 1 the active-level half
    logic [NUM_PH-1:0] ph_load, ph_run, ph_exp;
    logic [DIV_W-1:0]  ph_val;
    logic              accept;
    logic              lead_half;

    // Flat views for the bound checker
    logic              sclk_raw;
    logic              cpol_cfg;
    logic [DIV_W+1:0]  cfg_flat;

    always_comb begin
        accept    = (r_q.st == ST_IDLE) && req_i;
        lead_half = !r_q.half[0];
        ph_val    = accept ? div_i : r_q.div;

        ph_run[0]  = ((r_q.st == ST_SHIFT) && lead_half) || (r_q.st == ST_TRAIL);
        ph_run[1]  = (r_q.st == ST_SHIFT) && !lead_half;
        ph_load[0] = accept || ((r_q.st == ST_SHIFT) && !lead_half && ph_exp[1]);
        ph_load[1] = (r_q.st == ST_SHIFT) && lead_half && ph_exp[0];
    end

    for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
        spi_hold_timer #(.CNT_W(DIV_W)) u_timer (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .load_i     (ph_load[g]),
            .load_val_i (ph_val),
            .run_i      (ph_run[g]),
            .expired_o  (ph_exp[g])
        );
    end

    always_comb begin
        r_d        = r_q;
        r_d.rx_vld = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.cs_n = 1'b1;
                r_d.sclk = 1'b0;
                r_d.mode = clk_mode_t'(mode_i);
                r_d.div  = div_i;
                if (req_i) begin
                    r_d.st   = ST_SHIFT;
                    r_d.half = '0;
                    r_d.cs_n = 1'b0;
                    r_d.tx   = tx_word_i;
                    r_d.rx   = '0;
                end
            end
            ST_SHIFT: begin
                if (lead_half && ph_exp[0]) begin
                    // leading edge of a bit
                    r_d.sclk = 1'b1;
                    r_d.half = r_q.half + 1'b1;
                    if (!r_q.mode.cpha) begin
                        r_d.rx = {r_q.rx[WORD_W-2:0], miso_i};
                    end else if (r_q.half != '0) begin
                        r_d.tx = {r_q.tx[WORD_W-2:0], 1'b0};
                    end
                end else if (!lead_half && ph_exp[1]) begin
                    // trailing edge of a bit
                    r_d.sclk = 1'b0;
                    if (r_q.mode.cpha) begin
                        r_d.rx = {r_q.rx[WORD_W-2:0], miso_i};
                    end else if (r_q.half != HALF_LAST) begin
                        r_d.tx = {r_q.tx[WORD_W-2:0], 1'b0};
                    end
                    if (r_q.half == HALF_LAST) begin
                        r_d.st = ST_TRAIL;
                    end else begin
                        r_d.half = r_q.half + 1'b1;
                    end
                end
            end
            ST_TRAIL: begin
                if (ph_exp[0]) begin
                    r_d.st     = ST_IDLE;
                    r_d.cs_n   = 1'b1;
                    r_d.rx_out = r_q.rx;
                    r_d.rx_vld = 1'b1;
                end
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.cs_n = 1'b1;
                r_d.sclk = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q      <= '0;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    spi_clk_polarity u_pol (
        .sclk_i   (r_q.sclk),
        .invert_i (r_q.mode.cpol),
        .sclk_o   (sclk_o)
    );

    assign ready_o    = (r_q.st == ST_IDLE);
    assign cs_no      = r_q.cs_n;
    assign mosi_o     = r_q.tx[WORD_W-1];
    assign rx_word_o  = r_q.rx_out;
    assign rx_valid_o = r_q.rx_vld;
    assign sclk_raw   = r_q.sclk;
    assign cpol_cfg   = r_q.mode.cpol;
    assign cfg_flat   = {r_q.div, r_q.mode};

endmodule

// File: rtl/spi_host_engine_chk.sv
module spi_host_engine_chk #(
    parameter int CFG_W = 10
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cs_no,
    input logic             ready_o,
    input logic             sclk_o,
    input logic             sclk_raw_i,
    input logic             cpol_i,
    input logic             rx_valid_o,
    input logic [CFG_W-1:0] cfg_i
);

    // R2
    idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_no && ready_o) |-> (sclk_o == cpol_i));

    // R3
    sclk_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sclk_raw_i) |-> !cs_no);

    // R7
    rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_o |=> !rx_valid_o);

    // R7
    rx_at_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_o |-> (cs_no && !$past(cs_no)));

    // R8
    cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cs_no && !$past(cs_no)) |-> $stable(cfg_i));

    // R9
    busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_no |-> !ready_o);

endmodule

bind spi_host_engine spi_host_engine_chk #(.CFG_W(DIV_W + 2)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_no      (cs_no),
    .ready_o    (ready_o),
    .sclk_o     (sclk_o),
    .sclk_raw_i (sclk_raw),
    .cpol_i     (cpol_cfg),
    .rx_valid_o (rx_valid_o),
    .cfg_i      (cfg_flat)
);

// File: tb/spi_host_engine_bench.sv
module spi_host_engine_bench;

    localparam int W  = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic          ready_o;
    logic [W-1:0]  tx_word_i = '0;
    logic [DW-1:0] div_i = '0;
    logic [1:0]    mode_i = '0;
    logic [W-1:0]  rx_word_o;
    logic          rx_valid_o;
    logic          sclk_o, cs_no, mosi_o;
    logic          miso = 1'b0;

    int vec = 0;
    int bad = 0;
    int cyc = 0;

    // values announced by the stimulus, latched by the slave model at CS fall
    int           exp_div = 0;
    logic [1:0]   exp_mode = '0;
    logic [W-1:0] exp_tx = '0;
    logic [W-1:0] exp_sw = '0;

    always #2 clk = ~clk;

    spi_host_engine #(.WORD_W(W), .DIV_W(DW)) u_spi_host_engine (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .ready_o(ready_o),
        .tx_word_i(tx_word_i), .div_i(div_i), .mode_i(mode_i),
        .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o), .sclk_o(sclk_o),
        .cs_no(cs_no), .mosi_o(mosi_o), .miso_i(miso)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    function automatic bit sample_edge(input int e, input logic cpha);
        return cpha ? (e > 0 && e % 2 == 0) : (e % 2 == 1);
    endfunction

    function automatic int slave_bit_idx(input int e, input logic cpha);
        if (cpha) return (e == 0) ? 0 : (e - 1) / 2;
        return e / 2;
    endfunction

    // slave model and pin monitor
    int           m_div, e_cnt, last_evt;
    logic [1:0]   m_mode;
    logic [W-1:0] m_tx, m_sw, mosi_cap;
    logic         prev_cs = 1'b1;
    logic         prev_sclk = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_cs && !cs_no) begin
                m_div = exp_div; m_mode = exp_mode; m_tx = exp_tx; m_sw = exp_sw;
                e_cnt = 0; last_evt = cyc; mosi_cap = '0;
                miso = m_sw[W-1];
            end else if (!cs_no && sclk_o != prev_sclk) begin
                int idx;
                e_cnt++;
                if (e_cnt == 1) chk(cyc - last_evt == m_div + 1, "R4 lead", cyc - last_evt, m_div + 1);
                else            chk(cyc - last_evt == m_div + 1, "R3 spacing", cyc - last_evt, m_div + 1);
                last_evt = cyc;
                if (sample_edge(e_cnt, m_mode[0])) mosi_cap = {mosi_cap[W-2:0], mosi_o};
                idx = slave_bit_idx(e_cnt, m_mode[0]);
                if (idx < W) miso = m_sw[W-1-idx];
            end else if (!prev_cs && cs_no) begin
                chk(cyc - last_evt == m_div + 1, "R4 lag", cyc - last_evt, m_div + 1);
                chk(e_cnt == 2 * W, "R3 edges", e_cnt, 2 * W);
                chk(mosi_cap == m_tx, "R5 mosi", mosi_cap, m_tx);
            end
        end
        prev_cs   = cs_no;
        prev_sclk = sclk_o;
    end

    task automatic wait_rx();
        @(negedge clk);
        while (!rx_valid_o) @(negedge clk);
    endtask

    task automatic do_xfer(input logic [W-1:0] tx, input logic [W-1:0] sw,
                           input logic [DW-1:0] dv, input logic [1:0] md, input bit perturb);
        @(negedge clk);
        mode_i = md; div_i = dv;
        @(negedge clk);
        chk(sclk_o == md[1], "R2 idle level", sclk_o, md[1]);
        chk(ready_o == 1'b1, "R9 ready idle", ready_o, 1);
        exp_div = dv; exp_mode = md; exp_tx = tx; exp_sw = sw;
        tx_word_i = tx; req_i = 1'b1;
        @(negedge clk);
        chk(cs_no == 1'b0, "R9 accept", cs_no, 0);
        chk(ready_o == 1'b0, "R9 busy", ready_o, 0);
        req_i = 1'b0;
        if (perturb) begin
            // R8: disturb every configuration input mid-transfer
            div_i = ~dv; mode_i = ~md; tx_word_i = ~tx;
        end
        wait_rx();
        chk(rx_word_o == sw, perturb ? "R8 rx word" : "R6 rx word", rx_word_o, sw);
        chk(cs_no == 1'b1, "R7 cs high at valid", cs_no, 1);
        @(negedge clk);
        chk(rx_valid_o == 1'b0, "R7 single pulse", rx_valid_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL R9 watchdog act=%0d exp=done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240315));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_no == 1'b1, "R1 cs", cs_no, 1);
        chk(rx_valid_o == 1'b0, "R1 valid", rx_valid_o, 0);
        chk(ready_o == 1'b1, "R1 ready", ready_o, 1);
        chk(sclk_o == 1'b0, "R1 sclk", sclk_o, 0);
        rst_n = 1'b1;

        // full-rate corners in every mode
        for (int m = 0; m < 4; m++) do_xfer(8'hA5, 8'h3C, 8'd0, m[1:0], 1'b0);
        do_xfer(8'hFF, 8'h00, 8'd1, 2'b00, 1'b0);
        do_xfer(8'h00, 8'hFF, 8'd1, 2'b11, 1'b0);
        // slowest rate, R3 boundary
        do_xfer(8'h81, 8'h7E, 8'd255, 2'b10, 1'b0);
        // R8 directed
        do_xfer(8'h5A, 8'hC3, 8'd3, 2'b01, 1'b1);

        // R9: back-to-back, completion and next acceptance coincide
        @(negedge clk);
        mode_i = 2'b01; div_i = 8'd2;
        @(negedge clk);
        exp_div = 2; exp_mode = 2'b01; exp_tx = 8'h96; exp_sw = 8'h4B;
        tx_word_i = 8'h96; req_i = 1'b1;
        @(negedge clk);
        tx_word_i = 8'h2D;
        wait_rx();
        chk(rx_word_o == 8'h4B, "R9 first word", rx_word_o, 8'h4B);
        chk(ready_o == 1'b1, "R9 ready at valid", ready_o, 1);
        exp_tx = 8'h2D; exp_sw = 8'hE1;
        @(negedge clk);
        chk(cs_no == 1'b0, "R9 one-clock gap", cs_no, 0);
        req_i = 1'b0;
        wait_rx();
        chk(rx_word_o == 8'hE1, "R9 second word", rx_word_o, 8'hE1);
        @(negedge clk);

        // constrained random
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] t, s;
            logic [DW-1:0] d;
            logic [1:0] m;
            t = W'($urandom); s = W'($urandom);
            d = DW'($urandom % 6); m = 2'($urandom);
            do_xfer(t, s, d, m, ($urandom % 3) == 0);
        end

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule